// File: doc/BRIEF.md
# Four-Channel 12-Bit Converter Register Front End

This block is the digital register path in front of a four-channel 12-bit converter. A host writes codes over a parallel bus into one of four staging registers, picked by a two-bit channel address, under active-low select and write strobes. A separate pair of strobes then moves all four staged codes into the four output registers in the same cycle. The output registers feed the converter cores. Another strobe pair can clear every output to the midscale code, which is 0 V in offset binary.

A width-select input chooses between two load modes. In full-width mode the whole 12-bit word is taken. In narrow mode, which suits an 8-bit host, the upper four bus lines are steered into the low nibble, and the upper eight bits of the staging register are left alone. A full word is then loaded as a wide write carrying the top eight bits, followed by a narrow write carrying the last four.

Each output register keeps its top three bits as seven equally weighted thermometer lines next to the nine low bits. For checking, the block also presents the plain binary code of every channel. All strobes are sampled on a system clock. A strobe that acts while held low is modelled as an update on every clock edge while it stays low, so the design is built from flip-flops only.

Top module: `quad_dac_front`

## Requirements
- R1: After reset, every channel's output code is 12'h800 and its thermometer lanes read 7'b0001111.
- R2: Channel n owns bits [12n+11:12n] of `dac_code`, bits [7n+6:7n] of `dac_therm` and bits [9n+8:9n] of `dac_low`. An address value n selects channel n for writes, where n is 0 to 3.
- R3: A staging register changes only on an edge where `cs_n` and `wr1_n` are both low. If either of them is high, no staging register changes.
- R4: When `wide_mode` is 1, a write stores all 12 data bits unchanged in the addressed staging register.
- R5: When `wide_mode` is 0, a write copies `data_in[11:8]` into bits [3:0] of the addressed staging register and leaves bits [11:4] unchanged.
- R6: On an edge where `wr2_n` and `xfer_n` are both low and the clear is not active, all four output registers load their staging registers together. The new codes appear after that edge.
- R7: On an edge where `wr2_n` and `clr_n` are both low, all four outputs become 12'h800. This clear wins over a transfer requested on the same edge.
- R8: When neither a transfer nor a clear is active, the output registers hold their values.
- R9: In every channel, thermometer line k is 1 exactly when code bits [11:9] exceed k, and `dac_low` equals code bits [8:0].
- R10: While `wr2_n` and `xfer_n` stay low, releasing `clr_n` brings the staged codes back on the outputs on the next edge.
- R11: With `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` all low, a word sampled on one edge appears at the addressed channel's output after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| data_in | input | 12 | Parallel data bus, bit 11 is the MSB |
| addr | input | 2 | Channel select for staging writes |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Staging write strobe, active low |
| wr2_n | input | 1 | Output-stage strobe, active low |
| xfer_n | input | 1 | Transfer request, active low |
| clr_n | input | 1 | Clear request, active low |
| wide_mode | input | 1 | 1: full 12-bit load, 0: low-nibble load from the upper lines |
| dac_therm | output | 28 | Seven thermometer lines per channel |
| dac_low | output | 36 | Nine low code bits per channel |
| dac_code | output | 48 | Plain 12-bit code per channel |

## Verification
The bench goes after the narrow write. A design that also rewrote the top eight bits, or took the nibble from the low bus lines, would show a wrong code after the next transfer. It applies clear and transfer on the same edge: with the wrong priority the outputs would pick up the staged codes instead of midscale. A held-transfer sequence checks that staged codes return once clear is released, which a design that copied midscale into the staging path would lose. Codes with top bits 000 and 111 check both ends of the thermometer. A single strobe of the select pair arrives with junk data, which a design that decodes the write wrongly would store.

// File: rtl/qdac_pkg.sv
// Package: shared action encoding for the converter register front end.
// Assumes: consumers decode at most one output-stage action per cycle.
package qdac_pkg;

    // Output-stage action chosen each cycle; CLEAR outranks LOAD.
    typedef enum logic [1:0] {
        OUT_HOLD  = 2'd0,
        OUT_LOAD  = 2'd1,
        OUT_CLEAR = 2'd2
    } out_act_e;

endpackage

// File: rtl/qdac_ctrl.sv
// Module: strobe decoder. Turns the active-low strobe levels into a staging
// write enable and a single output-stage action for this clock edge.
// Assumes: strobes are already synchronous to clk.
module qdac_ctrl
    import qdac_pkg::*;
(
    input  logic     cs_n,
    input  logic     wr1_n,
    input  logic     wr2_n,
    input  logic     xfer_n,
    input  logic     clr_n,
    output logic     stage_we,
    output out_act_e out_act
);

    // Staging write needs both select and first write strobe low.
    assign stage_we = ~cs_n & ~wr1_n;

    // Pick the output action; clear has priority over transfer.
    always_comb begin
        if (!wr2_n && !clr_n) begin
            out_act = OUT_CLEAR;
        end else if (!wr2_n && !xfer_n) begin
            out_act = OUT_LOAD;
        end else begin
            out_act = OUT_HOLD;
        end
    end

endmodule

// File: rtl/qdac_input_bank.sv
// Module: per-channel staging registers with full-width and narrow
// (low-nibble from upper bus lines) write modes.
// Assumes: CH is a power of two and DATA_W > NARROW_W.
module qdac_input_bank #(
    parameter int CH       = 4,
    parameter int DATA_W   = 12,
    parameter int NARROW_W = 8,
    localparam int ADDR_W  = (CH > 1) ? $clog2(CH) : 1,
    localparam int LOW_W   = DATA_W - NARROW_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stage_we,
    input  logic                 wide_mode,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data_in,
    output logic [CH*DATA_W-1:0] stage_flat
);

    logic [LOW_W-1:0] low_src;

    // Low-nibble source: the bus low lines when wide, the upper lines when narrow.
    assign low_src = wide_mode ? data_in[LOW_W-1:0] : data_in[DATA_W-1 -: LOW_W];

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic              sel;
        logic              hi_en;
        logic              lo_en;
        logic [DATA_W-1:0] stage_q;

        assign sel   = stage_we && (addr == ADDR_W'(c));
        assign hi_en = sel && wide_mode;
        assign lo_en = sel;

        // Upper field: written only by full-width writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[DATA_W-1:LOW_W] <= '0;
            end else if (hi_en) begin
                stage_q[DATA_W-1:LOW_W] <= data_in[DATA_W-1:LOW_W];
            end
        end

        // Low field: written by either mode from the steered source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[LOW_W-1:0] <= '0;
            end else if (lo_en) begin
                stage_q[LOW_W-1:0] <= low_src;
            end
        end

        assign stage_flat[c*DATA_W +: DATA_W] = stage_q;
    end

endmodule

// File: rtl/qdac_therm_enc.sv
// Module: binary-to-thermometer encoder for the top code bits.
// Assumes: output line k is set when the input value exceeds k.
module qdac_therm_enc #(
    parameter int MSB_W    = 3,
    localparam int THERM_W = (1 << MSB_W) - 1
) (
    input  logic [MSB_W-1:0]   bin,
    output logic [THERM_W-1:0] therm
);

    // One comparator per line.
    for (genvar k = 0; k < THERM_W; k++) begin : g_line
        assign therm[k] = (32'(bin) > k);
    end

endmodule

// File: rtl/qdac_output_bank.sv
// Module: output registers holding thermometer lines plus low bits per
// channel; loads all channels together, clears all to midscale.
// Assumes: one action per cycle from qdac_ctrl.
module qdac_output_bank
    import qdac_pkg::*;
#(
    parameter int CH       = 4,
    parameter int DATA_W   = 12,
    parameter int MSB_W    = 3,
    localparam int THERM_W = (1 << MSB_W) - 1,
    localparam int LSB_W   = DATA_W - MSB_W,
    localparam int MID_MSB = 1 << (MSB_W - 1),
    localparam logic [THERM_W-1:0] MID_THERM = THERM_W'((1 << MID_MSB) - 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  out_act_e              out_act,
    input  logic [CH*DATA_W-1:0]  stage_flat,
    output logic [CH*THERM_W-1:0] therm_flat,
    output logic [CH*LSB_W-1:0]   low_flat,
    output logic [CH*DATA_W-1:0]  code_flat
);

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [DATA_W-1:0]  stage_w;
        logic [THERM_W-1:0] therm_d;
        logic [THERM_W-1:0] therm_q;
        logic [LSB_W-1:0]   low_q;
        logic [MSB_W-1:0]   msb_bin;

        assign stage_w = stage_flat[c*DATA_W +: DATA_W];

        qdac_therm_enc #(.MSB_W(MSB_W)) u_enc (
            .bin   (stage_w[DATA_W-1 -: MSB_W]),
            .therm (therm_d)
        );

        // Output register: reset and clear force midscale, load copies stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                therm_q <= MID_THERM;
                low_q   <= '0;
            end else begin
                case (out_act)
                    OUT_CLEAR: begin
                        therm_q <= MID_THERM;
                        low_q   <= '0;
                    end
                    OUT_LOAD: begin
                        therm_q <= therm_d;
                        low_q   <= stage_w[LSB_W-1:0];
                    end
                    default: begin
                        therm_q <= therm_q;
                        low_q   <= low_q;
                    end
                endcase
            end
        end

        // Rebuild the binary top bits by counting set thermometer lines.
        always_comb begin
            msb_bin = '0;
            for (int k = 0; k < THERM_W; k++) begin
                msb_bin = msb_bin + MSB_W'(therm_q[k]);
            end
        end

        assign therm_flat[c*THERM_W +: THERM_W] = therm_q;
        assign low_flat[c*LSB_W +: LSB_W]       = low_q;
        assign code_flat[c*DATA_W +: DATA_W]    = {msb_bin, low_q};
    end

endmodule

// File: rtl/quad_dac_front.sv
// Module: top of the four-channel converter register front end.
// Two register stages: addressed staging writes, then a transfer to all
// output registers at once, with a clear to midscale.
// Assumes: all inputs synchronous to clk; rst_n is the power-on reset.
module quad_dac_front
    import qdac_pkg::*;
#(
    parameter int CH       = 4,
    parameter int DATA_W   = 12,
    parameter int MSB_W    = 3,
    parameter int NARROW_W = 8,
    localparam int ADDR_W  = (CH > 1) ? $clog2(CH) : 1,
    localparam int THERM_W = (1 << MSB_W) - 1,
    localparam int LSB_W   = DATA_W - MSB_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     data_in,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  cs_n,
    input  logic                  wr1_n,
    input  logic                  wr2_n,
    input  logic                  xfer_n,
    input  logic                  clr_n,
    input  logic                  wide_mode,
    output logic [CH*THERM_W-1:0] dac_therm,
    output logic [CH*LSB_W-1:0]   dac_low,
    output logic [CH*DATA_W-1:0]  dac_code
);

    logic                 stage_we;
    out_act_e             out_act;
    logic [CH*DATA_W-1:0] stage_flat;

    qdac_ctrl u_ctrl (
        .cs_n     (cs_n),
        .wr1_n    (wr1_n),
        .wr2_n    (wr2_n),
        .xfer_n   (xfer_n),
        .clr_n    (clr_n),
        .stage_we (stage_we),
        .out_act  (out_act)
    );

    qdac_input_bank #(.CH(CH), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_we   (stage_we),
        .wide_mode  (wide_mode),
        .addr       (addr),
        .data_in    (data_in),
        .stage_flat (stage_flat)
    );

    qdac_output_bank #(.CH(CH), .DATA_W(DATA_W), .MSB_W(MSB_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_act    (out_act),
        .stage_flat (stage_flat),
        .therm_flat (dac_therm),
        .low_flat   (dac_low),
        .code_flat  (dac_code)
    );

endmodule

// File: rtl/qdac_checker.sv
// Module: property checker for quad_dac_front, attached by bind below.
// Assumes: same parameter values as the bound instance.
module qdac_checker #(
    parameter int CH       = 4,
    parameter int DATA_W   = 12,
    parameter int MSB_W    = 3,
    localparam int ADDR_W  = (CH > 1) ? $clog2(CH) : 1,
    localparam int THERM_W = (1 << MSB_W) - 1,
    localparam int LSB_W   = DATA_W - MSB_W,
    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [DATA_W-1:0]     data_in,
    input logic [ADDR_W-1:0]     addr,
    input logic                  cs_n,
    input logic                  wr1_n,
    input logic                  wr2_n,
    input logic                  xfer_n,
    input logic                  clr_n,
    input logic                  wide_mode,
    input logic [CH*DATA_W-1:0]  stage_flat,
    input logic [CH*THERM_W-1:0] dac_therm,
    input logic [CH*LSB_W-1:0]   dac_low,
    input logic [CH*DATA_W-1:0]  dac_code
);

    // R3: staging is frozen unless both select and write strobe are low.
    assert_stage_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wr1_n) |=> $stable(stage_flat));

    // R6: transfer without clear copies all staging registers.
    assert_transfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr2_n && !xfer_n && clr_n) |=> (dac_code == $past(stage_flat)));

    // R8: no transfer and no clear keeps the outputs.
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr2_n || (xfer_n && clr_n)) |=> $stable(dac_code));

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [THERM_W-1:0] lane;
        logic [THERM_W-1:0] lane_inc;
        logic [DATA_W-1:0]  code_c;

        assign lane     = dac_therm[c*THERM_W +: THERM_W];
        assign lane_inc = lane + THERM_W'(1);
        assign code_c   = dac_code[c*DATA_W +: DATA_W];

        // R7: clear drives every channel to midscale, ahead of transfer.
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr2_n && !clr_n) |=> (code_c == MID));

        // R4: a full-width write stores the bus word in the addressed channel.
        assert_wide_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wr1_n && wide_mode && addr == ADDR_W'(c))
            |=> (stage_flat[c*DATA_W +: DATA_W] == $past(data_in)));

        // R5: a narrow write leaves the upper field of the channel untouched.
        assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wr1_n && !wide_mode && addr == ADDR_W'(c))
            |=> $stable(stage_flat[c*DATA_W + DATA_W - 1 : c*DATA_W + DATA_W - NARROW_LIM]));

        // R9: lanes are contiguous from line 0 and match the code.
        assert_therm_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ((lane_inc & lane) == '0) && ($countones(lane) == int'(code_c[DATA_W-1 -: MSB_W]))
            && (dac_low[c*LSB_W +: LSB_W] == code_c[LSB_W-1:0]));
    end

    localparam int NARROW_LIM = DATA_W - 4;

endmodule

bind quad_dac_front qdac_checker #(.CH(CH), .DATA_W(DATA_W), .MSB_W(MSB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_in    (data_in),
    .addr       (addr),
    .cs_n       (cs_n),
    .wr1_n      (wr1_n),
    .wr2_n      (wr2_n),
    .xfer_n     (xfer_n),
    .clr_n      (clr_n),
    .wide_mode  (wide_mode),
    .stage_flat (stage_flat),
    .dac_therm  (dac_therm),
    .dac_low    (dac_low),
    .dac_code   (dac_code)
);

// File: tb/sim_quad_dac_front.sv
// Scoreboard bench: the driver applies one cycle of strobes, updates a
// reference model built from the requirements and queues the expected codes;
// the monitor pops each entry on the falling edge and compares all outputs.
module sim_quad_dac_front;

    localparam int CH = 4;
    localparam int DW = 12;

    typedef struct {
        logic [CH*DW-1:0] code;
        int               req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DW-1:0]    data_in = '0;
    logic [1:0]       addr = '0;
    logic             cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1;
    logic             xfer_n = 1'b1, clr_n = 1'b1, wide_mode = 1'b1;
    logic [CH*7-1:0]  dac_therm;
    logic [CH*9-1:0]  dac_low;
    logic [CH*DW-1:0] dac_code;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    logic [DW-1:0] m_stage [CH];
    logic [DW-1:0] m_out   [CH];

    always #2.5 clk = ~clk;

    quad_dac_front u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .addr      (addr),
        .cs_n      (cs_n),
        .wr1_n     (wr1_n),
        .wr2_n     (wr2_n),
        .xfer_n    (xfer_n),
        .clr_n     (clr_n),
        .wide_mode (wide_mode),
        .dac_therm (dac_therm),
        .dac_low   (dac_low),
        .dac_code  (dac_code)
    );

    // Compare one expected set of codes against all three output buses (R2, R9).
    task automatic compare(input logic [CH*DW-1:0] exp_code, input int req);
        logic [CH*7-1:0] exp_therm;
        logic [CH*9-1:0] exp_low;
        for (int c = 0; c < CH; c++) begin
            for (int k = 0; k < 7; k++) begin
                exp_therm[c*7+k] = (int'(exp_code[c*DW+9 +: 3]) > k);
            end
            exp_low[c*9 +: 9] = exp_code[c*DW +: 9];
        end
        checks++;
        if (dac_code !== exp_code || dac_therm !== exp_therm || dac_low !== exp_low) begin
            errors++;
            $display("FAIL R%0d code=%h therm=%h low=%h expected code=%h therm=%h low=%h",
                     req, dac_code, dac_therm, dac_low, exp_code, exp_therm, exp_low);
        end
    endtask

    // Drive one cycle, step the model, queue the expected outputs.
    task automatic step(input logic [DW-1:0] d, input logic [1:0] a,
                        input logic cs, input logic w1, input logic w2,
                        input logic xf, input logic cl, input logic wd, input int req);
        logic clr_act, xfr_act;
        exp_t e;
        @(negedge clk);
        data_in = d; addr = a; cs_n = cs; wr1_n = w1; wr2_n = w2;
        xfer_n = xf; clr_n = cl; wide_mode = wd;
        @(posedge clk);
        #1;
        clr_act = !w2 && !cl;
        xfr_act = !w2 && !xf;
        for (int c = 0; c < CH; c++) begin
            if (clr_act)      m_out[c] = 12'h800;
            else if (xfr_act) m_out[c] = m_stage[c];
        end
        if (!cs && !w1) begin
            if (wd) m_stage[a] = d;
            else    m_stage[a][3:0] = d[11:8];
        end
        for (int c = 0; c < CH; c++) e.code[c*DW +: DW] = m_out[c];
        e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: pop and compare away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                compare(e.code, e.req);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < CH; c++) begin
            m_stage[c] = '0;
            m_out[c]   = 12'h800;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state is midscale on every channel.
        compare({CH{12'h800}}, 1);

        // R4, R2: full-width writes to each channel; outputs must not move (R8).
        step(12'h123, 2'd0, 0, 0, 1, 1, 1, 1, 4);
        step(12'hFFF, 2'd1, 0, 0, 1, 1, 1, 1, 2);
        step(12'h000, 2'd2, 0, 0, 1, 1, 1, 1, 2);
        step(12'h9A5, 2'd3, 0, 0, 1, 1, 1, 1, 8);
        // R3: single strobe low writes nothing.
        step(12'h555, 2'd0, 1, 0, 1, 1, 1, 1, 3);
        step(12'hAAA, 2'd1, 0, 1, 1, 1, 1, 1, 3);
        // R8: xfer low without wr2 does nothing.
        step(12'h777, 2'd2, 1, 1, 1, 0, 1, 1, 8);
        // R6: transfer all; R9 covers top bits 000 and 111.
        step(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, 6);
        step(12'h000, 2'd0, 1, 1, 1, 1, 1, 1, 9);
        // R3: junk written while strobes were split must not appear after transfer.
        step(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, 3);

        // R5: narrow load of channel 1: top eight bits, then nibble on D11..D8.
        step(12'hAB0, 2'd1, 0, 0, 1, 1, 1, 1, 5);
        step(12'h5C3, 2'd1, 0, 0, 1, 1, 1, 0, 5);
        step(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, 5);
        // R5: narrow write to channel 3 keeps its upper field.
        step(12'h2FF, 2'd3, 0, 0, 1, 1, 1, 0, 5);
        step(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, 5);

        // R7: clear alone, then clear together with transfer.
        step(12'h000, 2'd0, 1, 1, 0, 1, 0, 1, 7);
        step(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, 6);
        step(12'h000, 2'd0, 1, 1, 0, 0, 0, 1, 7);
        step(12'h000, 2'd0, 1, 1, 0, 0, 0, 1, 7);
        // R10: release clear while transfer is held; staged codes return.
        step(12'h000, 2'd0, 1, 1, 0, 0, 1, 1, 10);
        step(12'h000, 2'd0, 1, 1, 1, 1, 1, 1, 8);
        // R8: clear strobe without wr2 is ignored.
        step(12'h000, 2'd0, 1, 1, 1, 1, 0, 1, 8);

        // R11: fully open path, one new word per channel each cycle.
        step(12'h111, 2'd0, 0, 0, 0, 0, 1, 1, 11);
        step(12'hE22, 2'd1, 0, 0, 0, 0, 1, 1, 11);
        step(12'h633, 2'd2, 0, 0, 0, 0, 1, 1, 11);
        step(12'h844, 2'd3, 0, 0, 0, 0, 1, 1, 11);
        step(12'h844, 2'd3, 1, 1, 1, 1, 1, 1, 11);
        step(12'h000, 2'd0, 1, 1, 1, 1, 1, 1, 8);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule